// File: doc/BRIEF.md
# PCI Configuration Address Generator

This block turns a configuration request (bus number, device slot, function number and register offset) into the two values that a host bridge needs to issue a PCI configuration cycle through a 16 MB local aperture. The first value is the 24-bit offset into that aperture. The second is the 16-bit value for the window map register that steers the aperture. A request on bus 0 becomes a type 0 cycle with a one-hot device select line. A request on any other bus becomes a type 1 cycle, with bus, device and function packed into address fields.

For a type 0 cycle, the one-hot select bit is placed in the aperture offset for low slot numbers. For higher slot numbers it moves into the map register, because the aperture offset runs out of bits. The map value always carries the configuration cycle type in bits 3:1. Bit 0 is the low-address enable: it is clear for type 0 and set for type 1. Requests that cannot be encoded are refused with an error pulse.

The block accepts a request in any cycle in which `req_i` is high. It presents the registered result one cycle later, qualified by `rsp_valid_o`, or signals `rsp_err_o` instead. Issuing the bus cycle itself is left to the surrounding bridge.

Top module: `cfg_addr_gen`

## Requirements
- R1: After reset, `rsp_valid_o` and `rsp_err_o` are low and `cfg_off_o` and `cfg_map_o` are zero.
- R2: A request accepted at a clock edge produces, at the next edge, a one-cycle pulse on exactly one of `rsp_valid_o` or `rsp_err_o`; without a request, neither is raised.
- R3: For bus 0 with slot 0 to 12, `cfg_off_o` holds the function in bits 10:8, the register offset in bits 7:0, and a single select bit at position slot+11.
- R4: For bus 0 with slot 13 to 20, `cfg_off_o` carries no select bit, and `cfg_map_o` has a single select bit at position slot-5.
- R5: For bus 0, `cfg_map_o` bits 3:1 hold the configuration type code 101, and bit 0 (low-address enable) is 0; bits 7:4 are 0 (base value 0x000A).
- R6: For a nonzero bus, `cfg_off_o` holds the bus in bits 23:16, the slot in bits 15:11, the function in bits 10:8 and the register offset in bits 7:0; `cfg_map_o` is 0x000B (type code 101 with low-address enable set).
- R7: A slot number above 31 or a function number above 7 gives `rsp_err_o` and no `rsp_valid_o`.
- R8: On bus 0, a register offset with bits 1:0 not both zero gives `rsp_err_o`.
- R9: On bus 0, a slot number from 21 to 31 gives `rsp_err_o`, since its select bit would lie above bit 15 of the map value.
- R10: A refused request leaves `cfg_off_o` and `cfg_map_o` at the values of the last accepted request.
- R11: Requests on consecutive cycles each produce their own result, in order, in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Request strobe; the request is taken at the rising edge |
| bus_i | input | 8 | Bus number |
| dev_i | input | 6 | Device slot number (values above 31 are refused) |
| fn_i | input | 4 | Function number (values above 7 are refused) |
| reg_i | input | 8 | Register offset within the function's configuration space |
| rsp_valid_o | output | 1 | One-cycle pulse: `cfg_off_o` and `cfg_map_o` hold a new result |
| rsp_err_o | output | 1 | One-cycle pulse: the last request was refused |
| cfg_off_o | output | 24 | Offset into the 16 MB configuration aperture |
| cfg_map_o | output | 16 | Window map register value |

## Verification
Two things can happen in the same cycle: the result of one request appears at the output while the next request is taken in. The bench issues requests on back-to-back cycles, including a refused request right after a good one and a type 1 request right after a type 0 request. At each step it checks that the pulse belongs to the request in flight. It also checks that the held offset and map values come from the last good request, not from the refused one.

// File: rtl/cfg_addr_pkg.sv
// Package: shared codes for the configuration address generator.
// Assumes: map register bit 0 is the low-address enable and bits 3:1 the type.
package cfg_addr_pkg;
    // Map register cycle-type code for configuration accesses
    localparam logic [2:0] MAP_TYPE_CONFIG = 3'b101;

    // Kind of configuration cycle chosen from the bus number
    typedef enum logic {
        CYC_TYPE0 = 1'b0,
        CYC_TYPE1 = 1'b1
    } cyc_kind_e;

    // Low nibble of the map value for a cycle kind
    function automatic logic [3:0] map_low(input cyc_kind_e kind);
        return {MAP_TYPE_CONFIG, (kind == CYC_TYPE1)};
    endfunction
endpackage

// File: rtl/cfg_req_check.sv
// Module: cfg_req_check
// Decides whether a request can be encoded. Refuses an out-of-range slot or
// function, and a type 0 request whose slot has no select bit or whose
// register offset is not word aligned.
// Assumes: MAX_T0_SLOT is the highest slot the map register can select.
module cfg_req_check #(
    parameter int DEV_W       = 6,
    parameter int FN_W        = 4,
    parameter int MAX_SLOT    = 31,
    parameter int MAX_FN      = 7,
    parameter int MAX_T0_SLOT = 20
) (
    input  logic [DEV_W-1:0] dev,
    input  logic [FN_W-1:0]  fn,
    input  logic [1:0]       reg_low,
    input  logic             is_type0,
    output logic             bad
);
    logic range_bad;
    logic t0_bad;

    // Range checks that apply to both cycle kinds
    always_comb begin
        range_bad = (dev > DEV_W'(MAX_SLOT)) || (fn > FN_W'(MAX_FN));
    end

    // Extra checks for type 0 cycles
    always_comb begin
        t0_bad = is_type0 && ((reg_low != 2'b00) || (dev > DEV_W'(MAX_T0_SLOT)));
    end

    // Combined refusal
    always_comb begin
        bad = range_bad || t0_bad;
    end
endmodule

// File: rtl/cfg_type0_enc.sv
// Module: cfg_type0_enc
// Builds the aperture offset and map value for a type 0 cycle. The one-hot
// select goes into the offset for slots up to SPLIT_SLOT and into the map
// value above it.
// Assumes: the slot has already been range checked.
module cfg_type0_enc
    import cfg_addr_pkg::*;
#(
    parameter int OFF_W         = 24,
    parameter int MAP_W         = 16,
    parameter int DEV_W         = 6,
    parameter int FN_FIELD_W    = 3,
    parameter int REG_W         = 8,
    parameter int SPLIT_SLOT    = 12,
    parameter int OFF_SEL_BASE  = 11,
    parameter int MAP_SEL_SHIFT = 5
) (
    input  logic [DEV_W-1:0]      dev,
    input  logic [FN_FIELD_W-1:0] fn,
    input  logic [REG_W-1:0]      regoff,
    output logic [OFF_W-1:0]      off,
    output logic [MAP_W-1:0]      map
);
    localparam int FN_LSB = REG_W;

    logic [OFF_W-1:0] off_sel;
    logic [MAP_W-1:0] map_sel;
    logic [OFF_W-1:0] off_fields;
    logic [MAP_W-1:0] map_fields;

    // One-hot select bits that land in the aperture offset
    for (genvar j = 0; j < OFF_W; j++) begin : g_off_sel
        if (j >= OFF_SEL_BASE && (j - OFF_SEL_BASE) <= SPLIT_SLOT) begin : g_hit
            assign off_sel[j] = (dev == DEV_W'(j - OFF_SEL_BASE));
        end else begin : g_none
            assign off_sel[j] = 1'b0;
        end
    end

    // One-hot select bits that land in the map value
    for (genvar k = 0; k < MAP_W; k++) begin : g_map_sel
        if ((k + MAP_SEL_SHIFT) > SPLIT_SLOT) begin : g_hit
            assign map_sel[k] = (dev == DEV_W'(k + MAP_SEL_SHIFT));
        end else begin : g_none
            assign map_sel[k] = 1'b0;
        end
    end

    // Function and register fields of the offset
    always_comb begin
        off_fields = '0;
        off_fields[REG_W-1:0] = regoff;
        off_fields[FN_LSB +: FN_FIELD_W] = fn;
    end

    // Type and low-address enable of the map value
    always_comb begin
        map_fields = '0;
        map_fields[3:0] = map_low(CYC_TYPE0);
    end

    // Merge fields and select bits
    always_comb begin
        off = off_fields | off_sel;
        map = map_fields | map_sel;
    end
endmodule

// File: rtl/cfg_type1_enc.sv
// Module: cfg_type1_enc
// Builds the aperture offset and map value for a type 1 cycle: bus, slot,
// function and register packed from the top bit down.
// Assumes: the packed fields exactly fill OFF_W bits.
module cfg_type1_enc
    import cfg_addr_pkg::*;
#(
    parameter int OFF_W       = 24,
    parameter int MAP_W       = 16,
    parameter int BUS_W       = 8,
    parameter int DEV_FIELD_W = 5,
    parameter int FN_FIELD_W  = 3,
    parameter int REG_W       = 8
) (
    input  logic [BUS_W-1:0]       bus,
    input  logic [DEV_FIELD_W-1:0] dev,
    input  logic [FN_FIELD_W-1:0]  fn,
    input  logic [REG_W-1:0]       regoff,
    output logic [OFF_W-1:0]       off,
    output logic [MAP_W-1:0]       map
);
    localparam int PACK_W = BUS_W + DEV_FIELD_W + FN_FIELD_W + REG_W;

    // Pack the address fields
    always_comb begin
        off = OFF_W'({bus, dev, fn, regoff});
    end

    // Type with low-address enable set
    always_comb begin
        map = '0;
        map[3:0] = map_low(CYC_TYPE1);
    end

    // Elaboration-time width guard
    initial begin
        if (PACK_W != OFF_W) $display("cfg_type1_enc: field widths do not fill the offset");
    end
endmodule

// File: rtl/cfg_addr_gen.sv
// Module: cfg_addr_gen (top)
// Accepts a configuration request and, one cycle later, presents the
// aperture offset and map value, or an error pulse. A refused request
// leaves the previous result on the outputs.
// Assumes: a request is taken in every cycle in which req_i is high.
module cfg_addr_gen
    import cfg_addr_pkg::*;
#(
    parameter int BUS_W         = 8,
    parameter int DEV_FIELD_W   = 5,
    parameter int FN_FIELD_W    = 3,
    parameter int REG_W         = 8,
    parameter int MAP_W         = 16,
    parameter int SPLIT_SLOT    = 12,
    parameter int OFF_SEL_BASE  = 11,
    parameter int MAP_SEL_SHIFT = 5,
    parameter int DEV_W         = DEV_FIELD_W + 1,
    parameter int FN_W          = FN_FIELD_W + 1,
    parameter int OFF_W         = BUS_W + DEV_FIELD_W + FN_FIELD_W + REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [BUS_W-1:0] bus_i,
    input  logic [DEV_W-1:0] dev_i,
    input  logic [FN_W-1:0]  fn_i,
    input  logic [REG_W-1:0] reg_i,
    output logic             rsp_valid_o,
    output logic             rsp_err_o,
    output logic [OFF_W-1:0] cfg_off_o,
    output logic [MAP_W-1:0] cfg_map_o
);
    localparam int MAX_SLOT    = (1 << DEV_FIELD_W) - 1;
    localparam int MAX_FN      = (1 << FN_FIELD_W) - 1;
    localparam int MAX_T0_SLOT = MAP_W - 1 + MAP_SEL_SHIFT;

    cyc_kind_e        kind;
    logic             bad;
    logic [OFF_W-1:0] t0_off;
    logic [MAP_W-1:0] t0_map;
    logic [OFF_W-1:0] t1_off;
    logic [MAP_W-1:0] t1_map;
    logic [OFF_W-1:0] nxt_off;
    logic [MAP_W-1:0] nxt_map;

    // Cycle kind from the bus number
    always_comb begin
        kind = (bus_i == '0) ? CYC_TYPE0 : CYC_TYPE1;
    end

    cfg_req_check #(
        .DEV_W(DEV_W), .FN_W(FN_W), .MAX_SLOT(MAX_SLOT),
        .MAX_FN(MAX_FN), .MAX_T0_SLOT(MAX_T0_SLOT)
    ) u_check (
        .dev(dev_i), .fn(fn_i), .reg_low(reg_i[1:0]),
        .is_type0(kind == CYC_TYPE0), .bad(bad)
    );

    cfg_type0_enc #(
        .OFF_W(OFF_W), .MAP_W(MAP_W), .DEV_W(DEV_W), .FN_FIELD_W(FN_FIELD_W),
        .REG_W(REG_W), .SPLIT_SLOT(SPLIT_SLOT), .OFF_SEL_BASE(OFF_SEL_BASE),
        .MAP_SEL_SHIFT(MAP_SEL_SHIFT)
    ) u_t0 (
        .dev(dev_i), .fn(fn_i[FN_FIELD_W-1:0]), .regoff(reg_i),
        .off(t0_off), .map(t0_map)
    );

    cfg_type1_enc #(
        .OFF_W(OFF_W), .MAP_W(MAP_W), .BUS_W(BUS_W), .DEV_FIELD_W(DEV_FIELD_W),
        .FN_FIELD_W(FN_FIELD_W), .REG_W(REG_W)
    ) u_t1 (
        .bus(bus_i), .dev(dev_i[DEV_FIELD_W-1:0]), .fn(fn_i[FN_FIELD_W-1:0]),
        .regoff(reg_i), .off(t1_off), .map(t1_map)
    );

    // Pick the encoder result for the cycle kind
    always_comb begin
        nxt_off = (kind == CYC_TYPE0) ? t0_off : t1_off;
        nxt_map = (kind == CYC_TYPE0) ? t0_map : t1_map;
    end

    // Response pulses and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_o <= 1'b0;
            rsp_err_o   <= 1'b0;
            cfg_off_o   <= '0;
            cfg_map_o   <= '0;
        end else begin
            rsp_valid_o <= req_i && !bad;
            rsp_err_o   <= req_i && bad;
            if (req_i && !bad) begin
                cfg_off_o <= nxt_off;
                cfg_map_o <= nxt_map;
            end
        end
    end
endmodule

// File: rtl/cfg_addr_gen_chk.sv
// Module: cfg_addr_gen_chk
// Temporal checks on the ports of cfg_addr_gen, bound to every instance.
// Assumes: default parameter values of the top.
module cfg_addr_gen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_i,
    input logic [7:0]  bus_i,
    input logic [5:0]  dev_i,
    input logic [3:0]  fn_i,
    input logic [7:0]  reg_i,
    input logic        rsp_valid_o,
    input logic        rsp_err_o,
    input logic [23:0] cfg_off_o,
    input logic [15:0] cfg_map_o
);
    AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> (rsp_valid_o ^ rsp_err_o)); // R2
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !(rsp_valid_o || rsp_err_o)); // R2
    AST_MAP_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> (cfg_map_o[3:1] == 3'b101)); // R5
    AST_BAD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && (dev_i > 6'd31 || fn_i > 4'd7)) |=> rsp_err_o); // R7
    AST_T0_MISALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && bus_i == 8'd0 && reg_i[1:0] != 2'b00) |=> rsp_err_o); // R8
    AST_T1_LOWEN: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && bus_i != 8'd0 && dev_i <= 6'd31 && fn_i <= 4'd7) |=> (rsp_valid_o && cfg_map_o[0])); // R6
    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err_o |-> ($stable(cfg_off_o) && $stable(cfg_map_o))); // R10
    AST_T0_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && !cfg_map_o[0]) |-> ($countones({cfg_off_o[23:11], cfg_map_o[15:8]}) == 1)); // R3
endmodule

bind cfg_addr_gen cfg_addr_gen_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .bus_i(bus_i), .dev_i(dev_i),
    .fn_i(fn_i), .reg_i(reg_i), .rsp_valid_o(rsp_valid_o), .rsp_err_o(rsp_err_o),
    .cfg_off_o(cfg_off_o), .cfg_map_o(cfg_map_o)
);

// File: tb/sim_cfg_addr_gen.sv
// Directed bench for cfg_addr_gen: one task per scenario.
module sim_cfg_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [7:0]  bus_i = '0;
    logic [5:0]  dev_i = '0;
    logic [3:0]  fn_i = '0;
    logic [7:0]  reg_i = '0;
    logic        rsp_valid_o;
    logic        rsp_err_o;
    logic [23:0] cfg_off_o;
    logic [15:0] cfg_map_o;

    int errors = 0;
    int checks = 0;
    bit finished = 0;
    logic [23:0] held_off = '0;
    logic [15:0] held_map = '0;

    always #10 clk = ~clk;

    cfg_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .bus_i(bus_i), .dev_i(dev_i),
        .fn_i(fn_i), .reg_i(reg_i), .rsp_valid_o(rsp_valid_o), .rsp_err_o(rsp_err_o),
        .cfg_off_o(cfg_off_o), .cfg_map_o(cfg_map_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected result computed from the requirements
    task automatic model(input logic [7:0] b, input logic [5:0] d, input logic [3:0] f,
                         input logic [7:0] r, output bit e, output logic [23:0] o,
                         output logic [15:0] m);
        e = (d > 31) || (f > 7) || (b == 0 && (r[1:0] != 0 || d > 20));
        if (b == 0) begin
            o = {13'd0, f[2:0], r};
            if (d <= 12) o = o | (24'd1 << (d + 11));
            m = 16'h000A;
            if (d > 12) m = m | (16'd1 << (d - 5));
        end else begin
            o = {b, d[4:0], f[2:0], r};
            m = 16'h000B;
        end
    endtask

    task automatic drive(input logic [7:0] b, input logic [5:0] d, input logic [3:0] f,
                         input logic [7:0] r);
        req_i = 1'b1; bus_i = b; dev_i = d; fn_i = f; reg_i = r;
    endtask

    // Compare outputs against the model of the request taken one edge earlier
    task automatic expect_for(input string tag, input logic [7:0] b, input logic [5:0] d,
                              input logic [3:0] f, input logic [7:0] r);
        bit e; logic [23:0] o; logic [15:0] m;
        model(b, d, f, r, e, o, m);
        check({tag, " R2 valid"}, 32'(rsp_valid_o), 32'(!e));
        check({tag, " R2 err"}, 32'(rsp_err_o), 32'(e));
        if (!e) begin held_off = o; held_map = m; end
        check({tag, " off (R10 when refused)"}, 32'(cfg_off_o), 32'(held_off));
        check({tag, " map (R10 when refused)"}, 32'(cfg_map_o), 32'(held_map));
    endtask

    task automatic single(input string tag, input logic [7:0] b, input logic [5:0] d,
                          input logic [3:0] f, input logic [7:0] r);
        @(negedge clk); drive(b, d, f, r);
        @(negedge clk); req_i = 1'b0;
        expect_for(tag, b, d, f, r);
    endtask

    task automatic t_reset;
        check("R1 valid", 32'(rsp_valid_o), 0);
        check("R1 err", 32'(rsp_err_o), 0);
        check("R1 off", 32'(cfg_off_o), 0);
        check("R1 map", 32'(cfg_map_o), 0);
    endtask

    task automatic t_type0_low;
        single("R3 slot0", 8'd0, 6'd0, 4'd0, 8'h00);
        single("R3 slot5 fn3 reg10", 8'd0, 6'd5, 4'd3, 8'h10);
        single("R3 slot12 fn7 regFC", 8'd0, 6'd12, 4'd7, 8'hFC);
        check("R5 type0 map base", 32'(cfg_map_o), 32'h000A);
    endtask

    task automatic t_type0_high;
        single("R4 slot13", 8'd0, 6'd13, 4'd1, 8'h04);
        check("R4 slot13 map bit8", 32'(cfg_map_o), 32'h010A);
        single("R4 slot20", 8'd0, 6'd20, 4'd6, 8'h40);
        check("R4 slot20 offset no select", 32'(cfg_off_o), 32'h000640);
    endtask

    task automatic t_type1;
        single("R6 bus1", 8'd1, 6'd3, 4'd2, 8'h08);
        single("R6 busFF slot31 fn7", 8'hFF, 6'd31, 4'd7, 8'hFF);
        check("R6 pack", 32'(cfg_off_o), 32'hFFFFFF);
        single("R6 bus80 unaligned ok", 8'h80, 6'd21, 4'd0, 8'h03);
    endtask

    task automatic t_errors;
        single("R7 slot32", 8'd1, 6'd32, 4'd0, 8'h00);
        single("R7 fn8", 8'd0, 6'd1, 4'd8, 8'h00);
        single("R8 misaligned", 8'd0, 6'd2, 4'd0, 8'h01);
        single("R9 type0 slot21", 8'd0, 6'd21, 4'd0, 8'h00);
        single("R9 type0 slot31", 8'd0, 6'd31, 4'd0, 8'h00);
    endtask

    task automatic t_idle;
        @(negedge clk);
        check("R2 idle valid", 32'(rsp_valid_o), 0);
        check("R2 idle err", 32'(rsp_err_o), 0);
    endtask

    task automatic t_back_to_back;
        @(negedge clk); drive(8'd0, 6'd4, 4'd1, 8'h20);
        @(negedge clk); expect_for("R11 b2b t0", 8'd0, 6'd4, 4'd1, 8'h20);
        drive(8'd0, 6'd9, 4'd0, 8'h02);
        @(negedge clk); expect_for("R11 b2b refused", 8'd0, 6'd9, 4'd0, 8'h02);
        drive(8'd7, 6'd17, 4'd5, 8'h44);
        @(negedge clk); expect_for("R11 b2b t1", 8'd7, 6'd17, 4'd5, 8'h44);
        drive(8'd0, 6'd16, 4'd2, 8'h0C);
        @(negedge clk); req_i = 1'b0;
        expect_for("R11 b2b t0 high", 8'd0, 6'd16, 4'd2, 8'h0C);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_type0_low();
        t_type0_high();
        t_type1();
        t_errors();
        t_idle();
        t_back_to_back();
        t_idle();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule